// File: doc/BRIEF.md
# PCIe Root-Complex Power-Up Sequencer

This block brings a PCIe controller up as a root complex with no processor involved. A one-cycle start request in the idle phase sets off a fixed chain of actions. It turns on the two controller clocks, lets them settle, and releases the register-block reset. It then sets the controller mode and the endpoint-reset control field, and waits. It raises the endpoint-reset output bit and waits again. Only then does it release the power-up reset. After that it polls two status flags in turn: PHY SRAM initialisation complete, then the core-reset monitor. Between the two polls it sends a one-cycle acknowledge that the external SRAM load is finished.

Every wait is set in nanoseconds and turned into clock cycles from a clock-frequency parameter. The conversion rounds up, so no wait is ever shorter than required. One shared down-counter times all the waits and the poll intervals. Each poll samples its flag once per interval and gives up after a bounded number of intervals. A poll that gives up ends the run in a sticky error. A successful run ends in a sticky done. A synchronous abort returns the whole block to its reset state. A 3-bit phase code shows where the sequence stands, for debug.

Top module: `pcie_pwrup_seq`

## Requirements
- R1: After reset, every output is 0 and the phase code is 0 (idle).
- R2: A start pulse in idle sets both clock enables on the next clock edge. The register-block reset release follows exactly ceil(SETTLE_NS x CLK_HZ / 1e9) cycles later, and the power-up reset stays asserted (0) at that point.
- R3: When the register-block reset is released, the mode code becomes 0x04 (root complex; 0x00 would mean endpoint). The endpoint-reset control field becomes 4'b1101 in the same cycle: bit 3 input enable, bit 2 direct enable and bit 0 direct value set, with bit 1, the output bit, clear.
- R4: Bit 1 of the endpoint-reset control field is set exactly one endpoint-reset wait (ceil of PERST_NS in cycles) after the register-block reset release.
- R5: The power-up reset is released exactly one endpoint-reset wait after bit 1 is set, with the control field then reading 4'b1111.
- R6: Each wait is ceil(ns x CLK_HZ / 1e9) cycles, with a minimum of 1. At 1 MHz: 250 ns gives 1 cycle, and 100 us gives 100 cycles.
- R7: The SRAM-init-done flag is sampled every poll interval, counted from the power-up reset release. The first high sample produces a one-cycle external-load-done pulse. If none of ceil(LIMIT_NS / POLL_NS) samples is high, the error output is set instead.
- R8: The core-reset monitor flag is polled in the same way, counted from the acknowledge pulse. A high sample sets the done output, and a run of low samples that reaches the limit sets the error output.
- R9: Done and error are never high together, and each holds until an abort.
- R10: A start request is ignored in any phase other than idle. The timing of a running sequence is unchanged, and a finished sequence keeps its phase and outputs.
- R11: An abort, which takes priority over start, returns every output and the phase code to their reset values on the next clock edge, and a later start runs the full sequence again.
- R12: The phase code reads 0 idle, 1 clock settle, 2 endpoint-reset low, 3 endpoint-reset high, 4 SRAM poll, 5 core-reset poll, 6 done and 7 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, honoured only in idle |
| abort | input | 1 | Synchronous return to the reset state |
| sramInitDone | input | 1 | PHY SRAM initialisation complete flag |
| coreRstMon | input | 1 | Controller core out-of-reset monitor flag |
| auxClkEn | output | 1 | Auxiliary clock enable |
| busClkEn | output | 1 | Master bus clock enable |
| regRstN | output | 1 | Register-block reset, 1 = released |
| pwrUpRstN | output | 1 | Power-up reset, 1 = released |
| modeCode | output | 8 | Controller mode code (0x04 root complex) |
| perstCtrl | output | 4 | Endpoint-reset control field |
| extLoadDone | output | 1 | One-cycle external-load-done acknowledge |
| seqDone | output | 1 | Sequence finished successfully |
| seqErr | output | 1 | Poll timed out |
| phase | output | 3 | Current phase code |

## Verification
The properties assume that both status flags are synchronous to the clock and change only between edges. They also assume that start and abort are single-cycle, level-sampled inputs. The bench drives every input on the falling edge, and it steps each flag from low to high at a cycle it chooses. That cycle is set either inside a given poll window, or just at its last sample, or just after it, so that the step falls on both sides of the timeout boundary. Extra start pulses are sent mid-run, after completion and together with abort, which keeps all inputs within those assumptions while covering the ignore and priority rules.

// File: rtl/pcie_pwrup_pkg.sv
package pcie_pwrup_pkg;

  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_CLK_SETTLE = 3'd1,
    PH_PERST_LOW  = 3'd2,
    PH_PERST_HIGH = 3'd3,
    PH_SRAM_POLL  = 3'd4,
    PH_CORE_POLL  = 3'd5,
    PH_DONE       = 3'd6,
    PH_FAIL       = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    LD_SETTLE = 2'd0,
    LD_PERST  = 2'd1,
    LD_POLL   = 2'd2
  } loadSel_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic     clear;     // abort: back to reset values
    logic     clkOn;     // enable both controller clocks
    logic     relReg;    // release register-block reset, set mode and endpoint-reset field
    logic     perstOut;  // raise endpoint-reset output bit
    logic     relPwr;    // release power-up reset
    logic     load;      // reload the shared down-counter
    loadSel_e loadSel;   // which delay to load
    logic     tick;      // decrement the shared down-counter
    logic     pollInit;  // reload the poll budget
    logic     pollDec;   // consume one poll sample
    logic     ack;       // external-load-done pulse
    logic     done;      // set sticky done
    logic     fail;      // set sticky error
  } seqStrobe_t;

  localparam logic [7:0] MODE_ROOT  = 8'h04;
  localparam logic [3:0] PERST_INIT = 4'b1101;
  localparam int         PERST_OUT_BIT = 1;

  // Round a delay up to whole clock cycles, never below one
  function automatic longint nsToCycles(input longint ns, input longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/pcie_pwrup_ctrl.sv
module pcie_pwrup_ctrl
  import pcie_pwrup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       abort,
  input  logic       sramInitDone,
  input  logic       coreRstMon,
  input  logic       timerZero,
  input  logic       pollLast,
  output seqStrobe_t stb,
  output phase_e     phaseQ
);

  phase_e phaseD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  always_comb begin
    stb    = '0;
    phaseD = phaseQ;
    if (abort) begin
      stb.clear = 1'b1;
      phaseD    = PH_IDLE;
    end else begin
      unique case (phaseQ)
        PH_IDLE: begin
          if (start) begin
            stb.clkOn   = 1'b1;
            stb.load    = 1'b1;
            stb.loadSel = LD_SETTLE;
            phaseD      = PH_CLK_SETTLE;
          end
        end
        PH_CLK_SETTLE: begin
          if (timerZero) begin
            stb.relReg  = 1'b1;
            stb.load    = 1'b1;
            stb.loadSel = LD_PERST;
            phaseD      = PH_PERST_LOW;
          end else begin
            stb.tick = 1'b1;
          end
        end
        PH_PERST_LOW: begin
          if (timerZero) begin
            stb.perstOut = 1'b1;
            stb.load     = 1'b1;
            stb.loadSel  = LD_PERST;
            phaseD       = PH_PERST_HIGH;
          end else begin
            stb.tick = 1'b1;
          end
        end
        PH_PERST_HIGH: begin
          if (timerZero) begin
            stb.relPwr   = 1'b1;
            stb.load     = 1'b1;
            stb.loadSel  = LD_POLL;
            stb.pollInit = 1'b1;
            phaseD       = PH_SRAM_POLL;
          end else begin
            stb.tick = 1'b1;
          end
        end
        PH_SRAM_POLL: begin
          if (!timerZero) begin
            stb.tick = 1'b1;
          end else if (sramInitDone) begin
            stb.ack      = 1'b1;
            stb.load     = 1'b1;
            stb.loadSel  = LD_POLL;
            stb.pollInit = 1'b1;
            phaseD       = PH_CORE_POLL;
          end else if (pollLast) begin
            stb.fail = 1'b1;
            phaseD   = PH_FAIL;
          end else begin
            stb.load    = 1'b1;
            stb.loadSel = LD_POLL;
            stb.pollDec = 1'b1;
          end
        end
        PH_CORE_POLL: begin
          if (!timerZero) begin
            stb.tick = 1'b1;
          end else if (coreRstMon) begin
            stb.done = 1'b1;
            phaseD   = PH_DONE;
          end else if (pollLast) begin
            stb.fail = 1'b1;
            phaseD   = PH_FAIL;
          end else begin
            stb.load    = 1'b1;
            stb.loadSel = LD_POLL;
            stb.pollDec = 1'b1;
          end
        end
        default: ;  // done and error hold until abort
      endcase
    end
  end

endmodule

// File: rtl/pcie_pwrup_dp.sv
module pcie_pwrup_dp
  import pcie_pwrup_pkg::*;
#(
  parameter int SETTLE_CYC = 25,
  parameter int PERST_CYC  = 10000,
  parameter int POLL_CYC   = 10000,
  parameter int POLL_COUNT = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  output logic       timerZero,
  output logic       pollLast,
  output logic       auxClkEn,
  output logic       busClkEn,
  output logic       regRstN,
  output logic       pwrUpRstN,
  output logic [7:0] modeCode,
  output logic [3:0] perstCtrl,
  output logic       extLoadDone,
  output logic       seqDone,
  output logic       seqErr
);

  localparam int MAX_A   = (SETTLE_CYC > PERST_CYC) ? SETTLE_CYC : PERST_CYC;
  localparam int MAX_CYC = (MAX_A > POLL_CYC) ? MAX_A : POLL_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam int CW      = $clog2(POLL_COUNT + 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] PERST_LD  = TW'(PERST_CYC - 1);
  localparam logic [TW-1:0] POLL_LD   = TW'(POLL_CYC - 1);

  logic [TW-1:0] timer;
  logic [TW-1:0] loadVal;
  logic [CW-1:0] pollCnt;

  always_comb begin
    unique case (stb.loadSel)
      LD_SETTLE: loadVal = SETTLE_LD;
      LD_PERST:  loadVal = PERST_LD;
      default:   loadVal = POLL_LD;
    endcase
  end

  assign timerZero = (timer == '0);
  assign pollLast  = (pollCnt == CW'(1));

  // Shared down-counter and poll budget
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer   <= '0;
      pollCnt <= '0;
    end else if (stb.clear) begin
      timer   <= '0;
      pollCnt <= '0;
    end else begin
      if (stb.load)      timer <= loadVal;
      else if (stb.tick) timer <= timer - 1'b1;
      if (stb.pollInit)     pollCnt <= CW'(POLL_COUNT);
      else if (stb.pollDec) pollCnt <= pollCnt - 1'b1;
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxClkEn    <= 1'b0;
      busClkEn    <= 1'b0;
      regRstN     <= 1'b0;
      pwrUpRstN   <= 1'b0;
      modeCode    <= '0;
      perstCtrl   <= '0;
      extLoadDone <= 1'b0;
      seqDone     <= 1'b0;
      seqErr      <= 1'b0;
    end else if (stb.clear) begin
      auxClkEn    <= 1'b0;
      busClkEn    <= 1'b0;
      regRstN     <= 1'b0;
      pwrUpRstN   <= 1'b0;
      modeCode    <= '0;
      perstCtrl   <= '0;
      extLoadDone <= 1'b0;
      seqDone     <= 1'b0;
      seqErr      <= 1'b0;
    end else begin
      if (stb.clkOn) begin
        auxClkEn <= 1'b1;
        busClkEn <= 1'b1;
      end
      if (stb.relReg) begin
        regRstN   <= 1'b1;
        modeCode  <= MODE_ROOT;
        perstCtrl <= PERST_INIT;
      end
      if (stb.perstOut) perstCtrl[PERST_OUT_BIT] <= 1'b1;
      if (stb.relPwr)   pwrUpRstN <= 1'b1;
      extLoadDone <= stb.ack;
      if (stb.done) seqDone <= 1'b1;
      if (stb.fail) seqErr  <= 1'b1;
    end
  end

endmodule

// File: rtl/pcie_pwrup_seq.sv
module pcie_pwrup_seq
  import pcie_pwrup_pkg::*;
#(
  parameter longint CLK_HZ    = 100_000_000,
  parameter longint SETTLE_NS = 250,
  parameter longint PERST_NS  = 100_000,
  parameter longint POLL_NS   = 100_000,
  parameter longint LIMIT_NS  = 1_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       abort,
  input  logic       sramInitDone,
  input  logic       coreRstMon,
  output logic       auxClkEn,
  output logic       busClkEn,
  output logic       regRstN,
  output logic       pwrUpRstN,
  output logic [7:0] modeCode,
  output logic [3:0] perstCtrl,
  output logic       extLoadDone,
  output logic       seqDone,
  output logic       seqErr,
  output logic [2:0] phase
);

  localparam int SETTLE_CYC = int'(nsToCycles(SETTLE_NS, CLK_HZ));
  localparam int PERST_CYC  = int'(nsToCycles(PERST_NS, CLK_HZ));
  localparam int POLL_CYC   = int'(nsToCycles(POLL_NS, CLK_HZ));
  localparam int POLL_COUNT = int'((LIMIT_NS + POLL_NS - 1) / POLL_NS);

  seqStrobe_t stb;
  phase_e     phaseQ;
  logic       timerZero;
  logic       pollLast;

  pcie_pwrup_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .abort        (abort),
    .sramInitDone (sramInitDone),
    .coreRstMon   (coreRstMon),
    .timerZero    (timerZero),
    .pollLast     (pollLast),
    .stb          (stb),
    .phaseQ       (phaseQ)
  );

  pcie_pwrup_dp #(
    .SETTLE_CYC (SETTLE_CYC),
    .PERST_CYC  (PERST_CYC),
    .POLL_CYC   (POLL_CYC),
    .POLL_COUNT (POLL_COUNT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .timerZero   (timerZero),
    .pollLast    (pollLast),
    .auxClkEn    (auxClkEn),
    .busClkEn    (busClkEn),
    .regRstN     (regRstN),
    .pwrUpRstN   (pwrUpRstN),
    .modeCode    (modeCode),
    .perstCtrl   (perstCtrl),
    .extLoadDone (extLoadDone),
    .seqDone     (seqDone),
    .seqErr      (seqErr)
  );

  assign phase = phaseQ;

endmodule

// File: rtl/pcie_pwrup_seq_chk.sv
module pcie_pwrup_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       abort,
  input logic       sramInitDone,
  input logic       coreRstMon,
  input logic       auxClkEn,
  input logic       busClkEn,
  input logic       regRstN,
  input logic       pwrUpRstN,
  input logic [7:0] modeCode,
  input logic [3:0] perstCtrl,
  input logic       extLoadDone,
  input logic       seqDone,
  input logic       seqErr,
  input logic [2:0] phase
);

  assert_clk_before_reg_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRstN) |-> (auxClkEn && busClkEn && !pwrUpRstN));

  assert_mode_root_R3: assert property (@(posedge clk) disable iff (!rstN)
    regRstN |-> (modeCode == 8'h04));

  assert_pwr_after_perst_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrUpRstN) |-> (perstCtrl == 4'hF && $past(perstCtrl) == 4'hF));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    extLoadDone |=> !extLoadDone);

  assert_ack_needs_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extLoadDone) |-> $past(sramInitDone));

  assert_done_needs_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> $past(coreRstMon));

  assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(seqDone && seqErr));

  assert_start_no_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 3'd0 && !abort) |=> (phase != 3'd0));

  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!auxClkEn && !busClkEn && !regRstN && !pwrUpRstN && modeCode == 8'h00
               && perstCtrl == 4'h0 && !extLoadDone && !seqDone && !seqErr && phase == 3'd0));

endmodule

bind pcie_pwrup_seq pcie_pwrup_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .abort        (abort),
  .sramInitDone (sramInitDone),
  .coreRstMon   (coreRstMon),
  .auxClkEn     (auxClkEn),
  .busClkEn     (busClkEn),
  .regRstN      (regRstN),
  .pwrUpRstN    (pwrUpRstN),
  .modeCode     (modeCode),
  .perstCtrl    (perstCtrl),
  .extLoadDone  (extLoadDone),
  .seqDone      (seqDone),
  .seqErr       (seqErr),
  .phase        (phase)
);

// File: tb/pcie_pwrup_seq_bench.sv
module pcie_pwrup_seq_bench;

  localparam int     CLK_PERIOD = 10;
  localparam longint FREQ_HZ    = 1_000_000;
  // Expected cycle counts at 1 MHz (R6): 250 ns -> 1, 100 us -> 100, 1000/100 -> 10 samples
  localparam int EXP_SETTLE = 1;
  localparam int EXP_PERST  = 100;
  localparam int EXP_POLL   = 100;
  localparam int EXP_NPOLL  = 10;
  localparam int RUN_LEN    = 1400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, abort = 1'b0, sramInitDone = 1'b0, coreRstMon = 1'b0;
  logic auxClkEn, busClkEn, regRstN, pwrUpRstN, extLoadDone, seqDone, seqErr;
  logic [7:0] modeCode;
  logic [3:0] perstCtrl;
  logic [2:0] phase;

  int nChk = 0, nBad = 0;

  // Observations from one run
  int kReg, kPerst, kPwr, kAck, ackCnt, kDone, kErr;
  int modeAtReg, perstAtReg, pwrAtReg, perstAtPwr, clkAt1;
  int ph1, ph2, ph102, ph202, phEnd;

  pcie_pwrup_seq #(.CLK_HZ(FREQ_HZ)) u_pcie_pwrup_seq (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort),
    .sramInitDone(sramInitDone), .coreRstMon(coreRstMon),
    .auxClkEn(auxClkEn), .busClkEn(busClkEn), .regRstN(regRstN), .pwrUpRstN(pwrUpRstN),
    .modeCode(modeCode), .perstCtrl(perstCtrl), .extLoadDone(extLoadDone),
    .seqDone(seqDone), .seqErr(seqErr), .phase(phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Sample cycle of a successful poll, or -1 when the poll runs out
  function automatic int expPoll(input int entry, input int setAt);
    for (int m = 1; m <= EXP_NPOLL; m++)
      if (setAt >= 0 && setAt <= entry + m * EXP_POLL - 1) return entry + m * EXP_POLL;
    return -1;
  endfunction

  task automatic checkIdle(input string req);
    chkEq(req, "clock enables", {auxClkEn, busClkEn}, 0);
    chkEq(req, "resets", {regRstN, pwrUpRstN}, 0);
    chkEq(req, "mode code", modeCode, 0);
    chkEq(req, "perst field", perstCtrl, 0);
    chkEq(req, "ack/done/err", {extLoadDone, seqDone, seqErr}, 0);
    chkEq(req, "phase", phase, 0);
  endtask

  task automatic doAbort();
    @(negedge clk) abort = 1'b1; start = 1'b1;
    @(negedge clk) abort = 1'b0; start = 1'b0;
    checkIdle("R11");
  endtask

  // Run one sequence; flags rise at the given sample index (-1 never)
  task automatic runSeq(input int sramAt, input int coreAt, input int restartAt);
    kReg = -1; kPerst = -1; kPwr = -1; kAck = -1; ackCnt = 0; kDone = -1; kErr = -1;
    modeAtReg = -1; perstAtReg = -1; pwrAtReg = -1; perstAtPwr = -1; clkAt1 = 0;
    ph1 = -1; ph2 = -1; ph102 = -1; ph202 = -1;
    sramInitDone = 1'b0; coreRstMon = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 1; k <= RUN_LEN; k++) begin
      if (k == 1) begin
        clkAt1 = (auxClkEn && busClkEn && !regRstN) ? 1 : 0;
        ph1 = phase;
      end
      if (k == 2) ph2 = phase;
      if (k == 102) ph102 = phase;
      if (k == 202) ph202 = phase;
      if (kReg < 0 && regRstN) begin
        kReg = k; modeAtReg = modeCode; perstAtReg = perstCtrl; pwrAtReg = pwrUpRstN;
      end
      if (kPerst < 0 && perstCtrl[1]) kPerst = k;
      if (kPwr < 0 && pwrUpRstN) begin
        kPwr = k; perstAtPwr = perstCtrl;
      end
      if (extLoadDone) begin
        ackCnt++;
        if (kAck < 0) kAck = k;
      end
      if (kDone < 0 && seqDone) kDone = k;
      if (kErr < 0 && seqErr) kErr = k;
      sramInitDone = (sramAt >= 0 && k >= sramAt);
      coreRstMon   = (coreAt >= 0 && k >= coreAt);
      start        = (k == restartAt);
      @(negedge clk);
    end
    phEnd = phase;
  endtask

  task automatic checkRun(input string tag, input int sramAt, input int coreAt);
    int ack, fin;
    chkEq("R2", {tag, " clocks on, regs held"}, clkAt1, 1);
    chkEq("R2", {tag, " reg reset release cycle"}, kReg, 1 + EXP_SETTLE);
    chkEq("R2", {tag, " power-up held at reg release"}, pwrAtReg, 0);
    chkEq("R3", {tag, " mode code"}, modeAtReg, 4);
    chkEq("R3", {tag, " perst field"}, perstAtReg, 4'b1101);
    chkEq("R4", {tag, " perst out cycle"}, kPerst, 1 + EXP_SETTLE + EXP_PERST);
    chkEq("R5", {tag, " power-up release cycle"}, kPwr, 1 + EXP_SETTLE + 2 * EXP_PERST);
    chkEq("R5", {tag, " perst at power-up"}, perstAtPwr, 4'b1111);
    chkEq("R12", {tag, " phases 1,2,3,4"}, {ph1[2:0], ph2[2:0], ph102[2:0], ph202[2:0]},
          {3'd1, 3'd2, 3'd3, 3'd4});
    ack = expPoll(kPwr, sramAt);
    chkEq("R7", {tag, " ack cycle"}, kAck, ack);
    chkEq("R7", {tag, " ack pulse count"}, ackCnt, (ack < 0) ? 0 : 1);
    if (ack < 0) begin
      chkEq("R7", {tag, " sram timeout cycle"}, kErr, kPwr + EXP_NPOLL * EXP_POLL);
      chkEq("R9", {tag, " no done"}, kDone, -1);
      chkEq("R12", {tag, " end phase"}, phEnd, 7);
    end else begin
      fin = expPoll(ack, coreAt);
      chkEq("R8", {tag, " done cycle"}, kDone, fin);
      chkEq("R8", {tag, " error cycle"}, kErr, (fin < 0) ? ack + EXP_NPOLL * EXP_POLL : -1);
      chkEq("R12", {tag, " end phase"}, phEnd, (fin < 0) ? 7 : 6);
    end
    chkEq("R9", {tag, " done/err held"}, seqDone ^ seqErr, 1);
  endtask

  task automatic testReset();
    checkIdle("R1");
  endtask

  task automatic testNominal();
    runSeq(150, 310, 50);           // R10: start pulse mid-run at sample 50
    checkRun("nominal", 150, 310);
    @(negedge clk) start = 1'b1;    // R10: start after completion is ignored
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R10", "phase after late start", phase, 6);
    chkEq("R10", "done after late start", seqDone, 1);
    chkEq("R10", "perst after late start", perstCtrl, 4'hF);
    doAbort();
  endtask

  task automatic testLateSram();
    runSeq(950, 0, -1);
    checkRun("late sram", 950, 0);
    doAbort();
  endtask

  task automatic testLastSample();
    runSeq(1201, 0, -1);            // R7: flag seen on the tenth and last sample
    checkRun("last sample", 1201, 0);
    doAbort();
  endtask

  task automatic testSramTimeout();
    runSeq(1202, 0, -1);            // R7: one cycle too late
    checkRun("sram timeout", 1202, 0);
    doAbort();
  endtask

  task automatic testCoreTimeout();
    runSeq(0, -1, -1);
    checkRun("core timeout", 0, -1);
    doAbort();
  endtask

  task automatic testAbortMidRun();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (149) @(negedge clk);
    chkEq("R11", "perst field before abort", perstCtrl, 4'hF);
    chkEq("R11", "phase before abort", phase, 3);
    doAbort();
    repeat (5) @(negedge clk);
    chkEq("R11", "stays idle after abort", phase, 0);
    runSeq(150, 310, -1);
    checkRun("after abort", 150, 310);
    doAbort();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNominal();
    testLateSram();
    testLastSample();
    testSramTimeout();
    testCoreTimeout();
    testAbortMidRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule